// File: doc/BRIEF.md
# Register Access Unlock Gate

This block guards the APB slave port of a configuration unit. After a power-on reset it accepts no register traffic. The very first APB transfer has to be a write of the key word 0x757BDF0D to the key register. If that first transfer is correct, the gate opens and a small register file becomes reachable. If the first transfer is anything else, the gate latches a rejected state. It then refuses every later transfer until the next power-on reset.

Behind the gate sit five registers. The control register drives two configuration outputs: one selects the internal configuration port, and the other slows that port to one word every four clocks. The lock register holds bits that can only be set. The identity register can be written until user mode begins. The status register reports the gate state and a sticky illegal-access flag. The auxiliary control register is plain read/write. A six-bit security strap input, when any bit is high, forbids all writes once the gate is open. Illegal transfers complete with the APB error response.

There are two resets. Power-on reset clears everything. Warm reset clears everything except the lock bits and the gate state.

Top module: `apb_unlock_gate`

## Requirements
- R1: `pready` is always 1. After power-on reset, a first transfer that is a read completes with `pslverr` high and `prdata` zero.
- R2: A first transfer that writes 0x757BDF0D to the key register (offset 0x34) completes without error and opens the gate. From then on, reads and writes to mapped registers complete with `pslverr` low.
- R3: A first transfer that is a read, a write to another offset, or a write of another value rejects the gate. Every later transfer then errors, including a correct key write, and has no effect on any register or output.
- R4: The lock register (offset 0x04) only gains bits. A write ORs the write data into it, and only power-on reset clears it.
- R5: Warm reset clears the control, identity and auxiliary registers and the illegal flag. It keeps the lock register contents and the open gate.
- R6: The identity register (offset 0x30) takes writes while `user_mode` is 0. While `user_mode` is 1, writes to it complete without error and leave it unchanged.
- R7: While the gate is open and any `strap_sec` bit is 1, every write completes with `pslverr` high and changes nothing, while reads still work. With all strap bits 0, writes are not restricted.
- R8: The status register (offset 0x14) reads bit0 = illegal access seen (sticky), bit1 = gate open, bit2 = gate rejected, bit3 = strap restriction active, and all other bits zero. Writes to it are ignored.
- R9: Control register (offset 0x00) bit0 drives `int_port_sel` and bit1 drives `quarter_rate`. Both outputs change in the cycle after the write completes.
- R10: Reads of the key register, the auxiliary register's unused offsets, unmapped offsets or unaligned addresses return zero without error. Writes to them change no register. The auxiliary control register lives at offset 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Warm reset, active low, asynchronous |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error response |
| strap_sec | input | 6 | Security straps, any high forbids writes |
| user_mode | input | 1 | User mode indication, freezes identity register |
| int_port_sel | output | 1 | Configuration routed to the internal port |
| quarter_rate | output | 1 | Internal port data at one word per four clocks |

## Verification
A wrong gate state shows up on `pslverr` in the access phase of the very next transfer. A gate stuck sealed or rejected errors on legal traffic, and a gate that opens wrongly lets a forbidden transfer finish without error. A corrupted lock, identity or control value appears on the next read of that offset, and a bad control value also appears on `int_port_sel` and `quarter_rate` one cycle after the write. Reset handling is exposed by reading back every register right after each kind of reset, and by checking whether the first transfer after power-on must again be the key write.

// File: rtl/agate_pkg.sv
package agate_pkg;
  localparam logic [31:0] UNLOCK_KEY = 32'h757B_DF0D;

  localparam int unsigned OFF_CTRL = 32'h00;
  localparam int unsigned OFF_LOCK = 32'h04;
  localparam int unsigned OFF_STAT = 32'h14;
  localparam int unsigned OFF_IDEN = 32'h30;
  localparam int unsigned OFF_KEY  = 32'h34;
  localparam int unsigned OFF_AUX  = 32'h80;

  typedef enum logic [1:0] {
    GATE_SEALED   = 2'd0,
    GATE_OPEN     = 2'd1,
    GATE_REJECTED = 2'd2
  } gate_state_e;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_CTRL = 3'd1,
    SEL_LOCK = 3'd2,
    SEL_STAT = 3'd3,
    SEL_IDEN = 3'd4,
    SEL_KEY  = 3'd5,
    SEL_AUX  = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/agate_addr_decode.sv
module agate_addr_decode
  import agate_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      if      (word == WORD_W'(OFF_CTRL / 4)) sel = SEL_CTRL;
      else if (word == WORD_W'(OFF_LOCK / 4)) sel = SEL_LOCK;
      else if (word == WORD_W'(OFF_STAT / 4)) sel = SEL_STAT;
      else if (word == WORD_W'(OFF_IDEN / 4)) sel = SEL_IDEN;
      else if (word == WORD_W'(OFF_KEY  / 4)) sel = SEL_KEY;
      else if (word == WORD_W'(OFF_AUX  / 4)) sel = SEL_AUX;
    end
  end
endmodule

// File: rtl/agate_unlock_fsm.sv
module agate_unlock_fsm
  import agate_pkg::*;
(
  input  logic        clk,
  input  logic        por_n,
  input  logic        xfer,
  input  logic        first_ok,
  output gate_state_e state
);
  gate_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (xfer && (state_q == GATE_SEALED))
      state_d = first_ok ? GATE_OPEN : GATE_REJECTED;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state_q <= GATE_SEALED;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R2
  open_holds_chk: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == GATE_OPEN) |=> (state_q == GATE_OPEN));

  // R3
  rejected_holds_chk: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == GATE_REJECTED) |=> (state_q == GATE_REJECTED));
endmodule

// File: rtl/agate_regfile.sv
module agate_regfile
  import agate_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MODE_BIT = 0,
  parameter int RATE_BIT = 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_n,
  input  logic              we,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              user_mode,
  input  logic              set_illegal,
  input  gate_state_e       gate_state,
  input  logic              restricted,
  output logic [DATA_W-1:0] rdata,
  output logic              mode_out,
  output logic              rate_out
);
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] lock_q, lock_d;
  logic [DATA_W-1:0] iden_q, iden_d;
  logic [DATA_W-1:0] aux_q,  aux_d;
  logic              ill_q,  ill_d;
  logic [DATA_W-1:0] status;

  always_comb begin
    ctrl_d = ctrl_q;
    lock_d = lock_q;
    iden_d = iden_q;
    aux_d  = aux_q;
    ill_d  = ill_q | set_illegal;
    if (we) begin
      case (sel)
        SEL_CTRL: ctrl_d = wdata;
        SEL_LOCK: lock_d = lock_q | wdata;
        SEL_IDEN: if (!user_mode) iden_d = wdata;
        SEL_AUX:  aux_d  = wdata;
        default:  ;
      endcase
    end
  end

  // lock bits: power-on reset only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) lock_q <= '0;
    else        lock_q <= lock_d;
  end

  always_ff @(posedge clk or negedge warm_n) begin
    if (!warm_n) begin
      ctrl_q <= '0;
      iden_q <= '0;
      aux_q  <= '0;
      ill_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      iden_q <= iden_d;
      aux_q  <= aux_d;
      ill_q  <= ill_d;
    end
  end

  always_comb begin
    status    = '0;
    status[0] = ill_q;
    status[1] = (gate_state == GATE_OPEN);
    status[2] = (gate_state == GATE_REJECTED);
    status[3] = restricted;
  end

  always_comb begin
    case (sel)
      SEL_CTRL: rdata = ctrl_q;
      SEL_LOCK: rdata = lock_q;
      SEL_STAT: rdata = status;
      SEL_IDEN: rdata = iden_q;
      SEL_AUX:  rdata = aux_q;
      default:  rdata = '0;
    endcase
  end

  assign mode_out = ctrl_q[MODE_BIT];
  assign rate_out = ctrl_q[RATE_BIT];

  // R4
  lock_monotonic_chk: assert property (@(posedge clk) disable iff (!por_n)
    por_n |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  // R6
  iden_frozen_chk: assert property (@(posedge clk) disable iff (!warm_n)
    (we && sel == SEL_IDEN && user_mode) |=> $stable(iden_q));

  // R8
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!warm_n)
    ill_q |=> ill_q);
endmodule

// File: rtl/apb_unlock_gate.sv
module apb_unlock_gate
  import agate_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int STRAP_W  = 6,
  parameter int MODE_BIT = 0,
  parameter int RATE_BIT = 1
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_n,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [DATA_W-1:0]  pwdata,
  output logic [DATA_W-1:0]  prdata,
  output logic               pready,
  output logic               pslverr,
  input  logic [STRAP_W-1:0] strap_sec,
  input  logic               user_mode,
  output logic               int_port_sel,
  output logic               quarter_rate
);
  // Both resets are assumed to be released synchronously upstream.
  logic        warm_n;
  logic        xfer;
  logic        first_ok;
  logic        restricted;
  logic        illegal;
  logic        reg_we;
  reg_sel_e    sel;
  gate_state_e state;
  logic [DATA_W-1:0] rf_rdata;

  assign warm_n     = por_n & rst_n;
  assign xfer       = psel & penable;
  assign restricted = |strap_sec;

  agate_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (paddr),
    .sel  (sel)
  );

  assign first_ok = pwrite && (sel == SEL_KEY) && (pwdata == DATA_W'(UNLOCK_KEY));

  agate_unlock_fsm u_fsm (
    .clk      (clk),
    .por_n    (por_n),
    .xfer     (xfer),
    .first_ok (first_ok),
    .state    (state)
  );

  always_comb begin
    case (state)
      GATE_SEALED: illegal = !first_ok;
      GATE_OPEN:   illegal = pwrite && restricted;
      default:     illegal = 1'b1;
    endcase
  end

  assign reg_we  = xfer && pwrite && !illegal && (state == GATE_OPEN);
  assign pslverr = xfer && illegal;
  assign pready  = 1'b1;

  agate_regfile #(
    .DATA_W   (DATA_W),
    .MODE_BIT (MODE_BIT),
    .RATE_BIT (RATE_BIT)
  ) u_regs (
    .clk         (clk),
    .por_n       (por_n),
    .warm_n      (warm_n),
    .we          (reg_we),
    .sel         (sel),
    .wdata       (pwdata),
    .user_mode   (user_mode),
    .set_illegal (pslverr),
    .gate_state  (state),
    .restricted  (restricted),
    .rdata       (rf_rdata),
    .mode_out    (int_port_sel),
    .rate_out    (quarter_rate)
  );

  assign prdata = (xfer && !pwrite && !illegal && state == GATE_OPEN) ? rf_rdata : '0;

  // R1
  sealed_read_err_chk: assert property (@(posedge clk) disable iff (!por_n)
    (xfer && !pwrite && state == GATE_SEALED) |-> (pslverr && prdata == '0));

  // R3
  rejected_err_chk: assert property (@(posedge clk) disable iff (!por_n)
    (xfer && state == GATE_REJECTED) |-> (pslverr && !reg_we));

  // R7
  strap_write_err_chk: assert property (@(posedge clk) disable iff (!por_n)
    (xfer && pwrite && state == GATE_OPEN && restricted) |-> (pslverr && !reg_we));
endmodule

// File: tb/apb_unlock_gate_tb.sv
module apb_unlock_gate_tb_top;
  localparam logic [31:0] KEY = 32'h757B_DF0D;
  localparam logic [7:0] A_CTRL = 8'h00, A_LOCK = 8'h04, A_STAT = 8'h14,
                         A_IDEN = 8'h30, A_KEY = 8'h34, A_AUX = 8'h80, A_NONE = 8'h40;

  logic        clk = 1'b0;
  logic        por_n, rst_n, psel, penable, pwrite, user_mode;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic        pready, pslverr, int_port_sel, quarter_rate;
  logic [5:0]  strap_sec;

  int n_chk = 0;
  int n_err = 0;
  logic done = 1'b0;

  logic [31:0] m_ctrl, m_lock, m_iden, m_aux;
  logic        m_ill;

  always #10 clk = ~clk;

  apb_unlock_gate dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .strap_sec(strap_sec),
    .user_mode(user_mode), .int_port_sel(int_port_sel), .quarter_rate(quarter_rate)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apb(input logic wr, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic err);
    @(negedge clk);
    psel = 1'b1; pwrite = wr; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #2;
    rd = prdata; err = pslverr;
    chk("R1 pready", {31'd0, pready}, 32'd1);
    @(posedge clk);
    #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic model_clear_warm();
    m_ctrl = '0; m_iden = '0; m_aux = '0; m_ill = 1'b0;
  endtask

  task automatic do_por();
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    model_clear_warm(); m_lock = '0;
  endtask

  task automatic do_warm();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_clear_warm();
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      A_CTRL: return m_ctrl;
      A_LOCK: return m_lock;
      A_STAT: return {28'd0, (strap_sec != 0), 1'b0, 1'b1, m_ill};
      A_IDEN: return m_iden;
      A_AUX:  return m_aux;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [31:0] d);
    if (strap_sec != 0) m_ill = 1'b1;
    else case (a)
      A_CTRL: m_ctrl = d;
      A_LOCK: m_lock = m_lock | d;
      A_IDEN: if (!user_mode) m_iden = d;
      A_AUX:  m_aux = d;
      default: ;
    endcase
  endtask

  // checked access against the model, open gate
  task automatic op(input string tag, input logic wr, input logic [7:0] a, input logic [31:0] d);
    logic [31:0] rd; logic err;
    apb(wr, a, d, rd, err);
    if (wr) begin
      chk({tag, " err"}, {31'd0, err}, {31'd0, (strap_sec != 0)});
      model_wr(a, d);
      chk({tag, " R9 outputs"}, {30'd0, quarter_rate, int_port_sel}, {30'd0, m_ctrl[1:0]});
    end else begin
      chk({tag, " err"}, {31'd0, err}, 32'd0);
      chk({tag, " data"}, rd, exp_rd(a));
    end
  endtask

  initial begin
    logic [31:0] rd; logic err;
    logic [7:0] addrs [7];
    addrs = '{A_CTRL, A_LOCK, A_STAT, A_IDEN, A_KEY, A_AUX, A_NONE};
    void'($urandom(32'd2024));
    por_n = 1'b0; rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; strap_sec = '0; user_mode = 1'b0;
    model_clear_warm(); m_lock = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;

    // R1: reset outputs, first access a read
    #1 chk("R1 reset outputs", {30'd0, quarter_rate, int_port_sel}, 32'd0);
    apb(1'b0, A_CTRL, 0, rd, err);
    chk("R1 first read err", {31'd0, err}, 32'd1);
    chk("R1 first read data", rd, 32'd0);
    // R3: rejected; key write and control write both refused
    apb(1'b1, A_KEY, KEY, rd, err);
    chk("R3 key after reject", {31'd0, err}, 32'd1);
    apb(1'b1, A_CTRL, 32'h3, rd, err);
    chk("R3 ctrl write err", {31'd0, err}, 32'd1);
    chk("R3 ctrl no effect", {30'd0, quarter_rate, int_port_sel}, 32'd0);

    // R3: key value at wrong offset
    do_por();
    apb(1'b1, A_CTRL, KEY, rd, err);
    chk("R3 wrong offset err", {31'd0, err}, 32'd1);
    apb(1'b0, A_LOCK, 0, rd, err);
    chk("R3 read after wrong offset", {31'd0, err}, 32'd1);
    // R3: wrong value
    do_por();
    apb(1'b1, A_KEY, KEY ^ 32'h1, rd, err);
    chk("R3 wrong value err", {31'd0, err}, 32'd1);
    apb(1'b1, A_KEY, KEY, rd, err);
    chk("R3 retry refused", {31'd0, err}, 32'd1);

    // R2: correct unlock
    do_por();
    apb(1'b1, A_KEY, KEY, rd, err);
    chk("R2 unlock err", {31'd0, err}, 32'd0);
    op("R8 status open", 1'b0, A_STAT, 0);
    op("R9 ctrl both", 1'b1, A_CTRL, 32'h3);
    op("R9 ctrl rate only", 1'b1, A_CTRL, 32'h2);
    op("R2 ctrl readback", 1'b0, A_CTRL, 0);
    // R4
    op("R4 lock set", 1'b1, A_LOCK, 32'h5);
    op("R4 lock zero write", 1'b1, A_LOCK, 32'h0);
    op("R4 lock read", 1'b0, A_LOCK, 0);
    op("R4 lock or", 1'b1, A_LOCK, 32'hA0);
    op("R4 lock read2", 1'b0, A_LOCK, 0);
    // R6
    op("R6 iden write", 1'b1, A_IDEN, 32'h1234);
    user_mode = 1'b1;
    op("R6 iden frozen write", 1'b1, A_IDEN, 32'hFFFF);
    op("R6 iden read", 1'b0, A_IDEN, 0);
    user_mode = 1'b0;
    // R10
    op("R10 key read", 1'b0, A_KEY, 0);
    op("R10 unmapped read", 1'b0, A_NONE, 0);
    op("R10 key rewrite", 1'b1, A_KEY, KEY);
    apb(1'b0, 8'h01, 0, rd, err);
    chk("R10 unaligned read", rd, 32'd0);
    // R8 status write ignored
    op("R8 status write", 1'b1, A_STAT, 32'hF);
    op("R8 status read", 1'b0, A_STAT, 0);
    // R7
    strap_sec = 6'b000100;
    op("R7 strap write", 1'b1, A_AUX, 32'h55);
    op("R7 strap read", 1'b0, A_AUX, 0);
    op("R8 status sticky", 1'b0, A_STAT, 0);
    strap_sec = 6'b100000;
    op("R7 strap ctrl write", 1'b1, A_CTRL, 32'h1);
    strap_sec = '0;
    op("R7 clear write", 1'b1, A_AUX, 32'h55);
    op("R7 clear read", 1'b0, A_AUX, 0);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      a = addrs[$urandom % 7];
      strap_sec = (($urandom % 8) == 0) ? 6'(1 << ($urandom % 6)) : 6'd0;
      user_mode = (($urandom % 4) == 0);
      op("R2 random", 1'($urandom % 2), a, $urandom);
    end
    strap_sec = '0; user_mode = 1'b0;
    op("R4 lock before warm", 1'b1, A_LOCK, 32'h8000_0001);

    // R5 warm reset
    do_warm();
    #1 chk("R5 outputs after warm", {30'd0, quarter_rate, int_port_sel}, 32'd0);
    op("R5 lock kept", 1'b0, A_LOCK, 0);
    op("R5 ctrl cleared", 1'b0, A_CTRL, 0);
    op("R5 aux cleared", 1'b0, A_AUX, 0);
    op("R5 iden cleared", 1'b0, A_IDEN, 0);
    op("R5 still open", 1'b0, A_STAT, 0);

    // R5 power-on reset clears lock; key required again
    do_por();
    apb(1'b0, A_LOCK, 0, rd, err);
    chk("R1 read after por err", {31'd0, err}, 32'd1);
    do_por();
    apb(1'b1, A_KEY, KEY, rd, err);
    chk("R2 unlock again", {31'd0, err}, 32'd0);
    op("R5 lock cleared by por", 1'b0, A_LOCK, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule